// File: doc/BRIEF.md
# Four-Lane Code-Group Deskew Unit

This block receives four lanes of 10-bit code-groups that have each been symbol-synchronized on their own but reach it with different link delays. It restores column alignment so that the four code-groups leaving the block in one cycle are the four that were sent together. The transmitter places an alignment code-group on every lane in the same column of the idle stream. The block uses those columns as its reference points.

Each lane writes every incoming code-group into a small circular buffer. While the block is searching, each lane records where its first alignment code-group was stored. Once all four lanes have recorded one, every lane starts reading from its own recorded position. From then on the output columns are aligned, and the lock flag rises together with the output column that holds the alignment code-groups.

While locked, the block keeps checking the output columns. A column that carries alignment code-groups on some lanes but not on all of them drops the lock and restarts the search. If the lanes' alignment code-groups are spread over more code-group times than the buffers can absorb, the search is abandoned and begins again.

Top module: `four_lane_deskew`

## Requirements
- R1: Lane n (n = 0..3) occupies bits [10n+9:10n] of both the input word and the output word. Lane 0 holds the earliest code-group of a column.
- R2: A code-group counts as an alignment code-group only when it equals 10'h0F3 or 10'h30C, which are the two running-disparity forms of K28.3. Any other value, including one that differs from either form by a single bit, is treated as ordinary data.
- R3: While `rst` is high at a rising clock edge, `align_done` and `aligned_o` are 0 after that edge.
- R4: `align_done` rises only together with an output column that carries alignment code-groups on all four lanes. From that column on, the output columns equal the transmitted columns in transmit order, with no offset between lanes, for any lane skew from 0 up to and including DEPTH-4 code-group times (4 with the default DEPTH of 8).
- R5: While locked, an output column whose alignment code-groups are on all lanes or on none keeps `align_done` high in the next cycle.
- R6: While locked, an output column that carries alignment code-groups on some lanes but not on all of them makes `align_done` low in the next cycle. The block then searches again and relocks at later alignment columns.
- R7: If the first and last lanes to show an alignment code-group during a search are more than DEPTH-4 code-group times apart, all recorded positions are discarded and the search starts over, so such a skew never produces a lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one code-group per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| lanes_i | input | 40 | Synchronized code-groups, lane n in bits [10n+9:10n] |
| aligned_o | output | 40 | Deskewed code-groups, same lane packing (registered) |
| align_done | output | 1 | High while the output columns are aligned (registered) |

## Verification
The four lanes are driven with per-lane delays of {0,2,1,4}, {0,0,0,0} and {3,0,4,1}. These runs separate correct per-lane read positions from a common delay or a swapped lane, because every output column is compared against the transmitted one. Alignment columns alternate between the two disparity forms, which checks that both are recognized. While locked, one lane's delay is changed mid-stream to provoke a partial alignment column, and the bench looks for the lock dropping and then returning. A lane skew of 5 and a lane that carries a near-miss value instead of the alignment code-group must both never lock. Together these cover the skew limit and exact marker matching.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

  // Width of one 8b/10b code-group
  localparam int CG_W = 10;

  // Alignment code-group (K28.3) in its two running-disparity forms
  localparam logic [CG_W-1:0] MARK_RDN = 10'h0F3;
  localparam logic [CG_W-1:0] MARK_RDP = 10'h30C;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_PRIME  = 2'd1,
    ST_LOCKED = 2'd2
  } dsk_state_e;

  function automatic logic is_marker(input logic [CG_W-1:0] cg);
    return (cg == MARK_RDN) || (cg == MARK_RDP);
  endfunction

endpackage

// File: rtl/dsk_lane_buf.sv
// One lane: circular code-group store, marker position capture, aligned read.
module dsk_lane_buf
  import dsk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [CG_W-1:0]   din,
  input  logic              search,
  input  logic              clear,
  input  logic              load,
  output logic              seen,
  output logic [CG_W-1:0]   dout
);

  logic [CG_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] mark_ptr;
  logic             seen_q;
  logic             arm;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Write port: every cycle, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    mem[wr_ptr] <= din;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else begin
      dout <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
    end else if (load) begin
      rd_ptr <= mark_ptr;
    end else begin
      rd_ptr <= ptr_inc(rd_ptr);
    end
  end

  // Record the first marker position seen during a search
  assign arm = search && !seen_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen_q   <= 1'b0;
      mark_ptr <= '0;
    end else if (arm && is_marker(din)) begin
      seen_q   <= 1'b1;
      mark_ptr <= wr_ptr;
    end
  end

  assign seen = seen_q;

endmodule

// File: rtl/dsk_col_check.sv
// Classifies an output column by how many lanes carry a marker.
module dsk_col_check
  import dsk_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*CG_W-1:0] col,
  output logic                  col_full,
  output logic                  col_partial
);

  logic [LANES-1:0] lane_mark;

  for (genvar g = 0; g < LANES; g++) begin : g_mark
    assign lane_mark[g] = is_marker(col[g*CG_W +: CG_W]);
  end

  assign col_full    = &lane_mark;
  assign col_partial = (|lane_mark) && !(&lane_mark);

endmodule

// File: rtl/dsk_ctrl.sv
// Search / prime / locked sequencing, shared write pointer, skew window.
module dsk_ctrl
  import dsk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int MAX_SKEW = DEPTH - 4,
  localparam int CNT_W    = $clog2(MAX_SKEW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  seen,
  input  logic              col_partial,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              search,
  output logic              clear,
  output logic              load,
  output logic              skew_abort,
  output logic              align_done
);

  dsk_state_e       state_q, state_d;
  logic [CNT_W-1:0] skew_cnt;
  logic             all_seen, any_seen;

  assign all_seen = &seen;
  assign any_seen = |seen;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ST_SEARCH: begin
        if (all_seen) begin
          state_d = ST_PRIME;
          load    = 1'b1;
        end
      end
      ST_PRIME:  state_d = ST_LOCKED;
      ST_LOCKED: begin
        if (col_partial) state_d = ST_SEARCH;
      end
      default:   state_d = ST_SEARCH;
    endcase
  end

  assign search     = (state_q == ST_SEARCH);
  assign skew_abort = search && any_seen && !all_seen &&
                      (skew_cnt == CNT_W'(MAX_SKEW));
  assign clear      = !search || skew_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_SEARCH;
      align_done <= 1'b0;
      wr_ptr     <= '0;
      skew_cnt   <= '0;
    end else begin
      state_q    <= state_d;
      align_done <= (state_d == ST_LOCKED);
      wr_ptr     <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (!search || !any_seen || skew_abort) begin
        skew_cnt <= '0;
      end else if (!all_seen) begin
        skew_cnt <= skew_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/four_lane_deskew.sv
module four_lane_deskew
  import dsk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int W     = LANES * CG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lanes_i,
  output logic [W-1:0] aligned_o,
  output logic         align_done
);

  logic [PTR_W-1:0] wr_ptr;
  logic [LANES-1:0] lane_seen;
  logic             search, clear, load, skew_abort;
  logic             col_full, col_partial;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dsk_lane_buf #(.DEPTH(DEPTH)) lane_i (
      .clk    (clk),
      .rst    (rst),
      .wr_ptr (wr_ptr),
      .din    (lanes_i[g*CG_W +: CG_W]),
      .search (search),
      .clear  (clear),
      .load   (load),
      .seen   (lane_seen[g]),
      .dout   (aligned_o[g*CG_W +: CG_W])
    );
  end

  dsk_col_check #(.LANES(LANES)) col_i (
    .col         (aligned_o),
    .col_full    (col_full),
    .col_partial (col_partial)
  );

  dsk_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .seen        (lane_seen),
    .col_partial (col_partial),
    .wr_ptr      (wr_ptr),
    .search      (search),
    .clear       (clear),
    .load        (load),
    .skew_abort  (skew_abort),
    .align_done  (align_done)
  );

endmodule

// File: rtl/four_lane_deskew_chk.sv
module four_lane_deskew_chk
  import dsk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [LANES*CG_W-1:0] aligned_o,
  input logic                  align_done,
  input logic [LANES-1:0]      seen,
  input logic                  skew_abort
);

  logic [LANES-1:0] m;
  always_comb begin
    for (int i = 0; i < LANES; i++) m[i] = is_marker(aligned_o[i*CG_W +: CG_W]);
  end

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!align_done && aligned_o == '0));

  // R4
  lock_on_marker_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(align_done) |-> (m == '1));

  // R5
  hold_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (align_done && (m == '1 || m == '0)) |=> align_done);

  // R6
  drop_on_partial_chk: assert property (@(posedge clk) disable iff (rst)
    (align_done && m != '1 && m != '0) |=> !align_done);

  // R7
  skew_abort_chk: assert property (@(posedge clk) disable iff (rst)
    skew_abort |=> (seen == '0));

endmodule

bind four_lane_deskew four_lane_deskew_chk #(.LANES(LANES), .DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .aligned_o  (aligned_o),
  .align_done (align_done),
  .seen       (lane_seen),
  .skew_abort (skew_abort)
);

// File: tb/four_lane_deskew_tb_top.sv
`timescale 1ns/1ps
module four_lane_deskew_tb_top;

  localparam int L = 4;
  localparam int W = 40;
  localparam logic [9:0] MK_N = 10'h0F3;
  localparam logic [9:0] MK_P = 10'h30C;
  localparam logic [9:0] NEAR = 10'h30D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] lanes_i = '0;
  logic [W-1:0] aligned_o;
  logic         align_done;

  always #5 clk = ~clk;

  four_lane_deskew dut_i (
    .clk(clk), .rst(rst), .lanes_i(lanes_i),
    .aligned_o(aligned_o), .align_done(align_done)
  );

  int n_chk = 0, n_fail = 0;
  int dly [L];
  logic [L-1:0] mark_en = '1;
  bit restart = 0, disturb = 0, lock_seen = 0;
  int drops = 0, cmps = 0;

  logic [W-1:0] hist [16];
  logic [W-1:0] sb_q [$];
  int seq = 0;
  int trk = 0;
  logic prev_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit col_marks(input logic [W-1:0] c);
    for (int i = 0; i < L; i++)
      if (c[i*10 +: 10] != MK_N && c[i*10 +: 10] != MK_P) return 0;
    return 1;
  endfunction

  // Driver: transmitted column, per-lane delay lines, scoreboard push
  always @(negedge clk) begin
    logic [W-1:0] col;
    logic [W-1:0] din;
    if (restart) begin
      for (int k = 0; k < 16; k++) hist[k] = '0;
      sb_q.delete();
      seq = 0;
      restart = 0;
    end
    for (int i = 0; i < L; i++) begin
      if (seq % 16 == 0)
        col[i*10 +: 10] = !mark_en[i] ? NEAR : (((seq / 16) % 2) ? MK_P : MK_N);
      else
        col[i*10 +: 10] = {2'b01, 8'(seq * 7 + i * 53)};
    end
    for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = col;
    for (int i = 0; i < L; i++) din[i*10 +: 10] = hist[dly[i]][i*10 +: 10];
    lanes_i = din;
    sb_q.push_back(col);
    seq++;
  end

  // Monitor: syncs on the first locked marker column, then compares in order
  always @(negedge clk) begin
    if (rst) begin
      trk = 0;
    end else begin
      if (prev_done && !align_done) drops++;
      if (align_done) lock_seen = 1;
      if (disturb) begin
        trk = 0;
        if (!align_done) disturb = 0;
      end else if (!align_done) begin
        trk = 0;
      end else begin
        case (trk)
          0: begin
            chk(col_marks(aligned_o), "R4", "first locked column not all markers",
                aligned_o, 0);
            trk = 1;
          end
          1: begin
            while (sb_q.size() >= 2 && !(col_marks(sb_q[0]) && sb_q[1] == aligned_o))
              void'(sb_q.pop_front());
            chk(sb_q.size() >= 2, "R4", "column after marker not found in stream",
                aligned_o, 0);
            if (sb_q.size() >= 2) begin
              void'(sb_q.pop_front());
              void'(sb_q.pop_front());
              cmps++;
            end
            trk = 2;
          end
          default: begin
            logic [W-1:0] e;
            e = (sb_q.size() > 0) ? sb_q.pop_front() : '1;
            chk(aligned_o == e, "R1/R4", "aligned column mismatch", aligned_o, e);
            cmps++;
          end
        endcase
      end
    end
    prev_done = align_done;
  end

  task automatic start(input int d0, input int d1, input int d2, input int d3,
                       input logic [L-1:0] men);
    @(posedge clk); #1;
    dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
    mark_en = men;
    restart = 1;
    rst = 1;
    lock_seen = 0; drops = 0; cmps = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  initial begin
    for (int i = 0; i < L; i++) dly[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: reset state
    chk(align_done == 1'b0, "R3", "align_done in reset", align_done, 0);
    chk(aligned_o == '0, "R3", "aligned_o in reset", aligned_o, 0);

    // Skews {0,2,1,4}: 4 is the largest skew that must lock
    start(0, 2, 1, 4, 4'hF);
    repeat (120) @(posedge clk);
    @(negedge clk);
    chk(lock_seen, "R4", "lock with skew up to 4", lock_seen, 1);
    chk(cmps > 60, "R1", "aligned columns compared", cmps, 61);
    chk(drops == 0, "R5", "lock held across marker columns", drops, 0);
    chk(align_done, "R5", "still locked", align_done, 1);

    // Shift lane 1 by one code-group while locked
    @(posedge clk); #1;
    disturb = 1;
    dly[1] = 3;
    drops = 0; cmps = 0;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(drops >= 1, "R6", "lock dropped on partial marker column", drops, 1);
    chk(align_done, "R6", "relocked after realign", align_done, 1);
    chk(cmps > 20, "R6", "columns compared after relock", cmps, 21);

    // Zero skew
    start(0, 0, 0, 0, 4'hF);
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(lock_seen && align_done, "R4", "lock with zero skew", align_done, 1);
    chk(cmps > 30, "R4", "columns compared zero skew", cmps, 31);

    // Mixed skews, markers alternate between both disparity forms
    start(3, 0, 4, 1, 4'hF);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(lock_seen && align_done, "R2", "lock with both marker forms", align_done, 1);
    chk(drops == 0, "R2", "no drop across alternating forms", drops, 0);

    // Skew of 5 exceeds the window
    start(0, 5, 0, 0, 4'hF);
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk(!lock_seen, "R7", "no lock with skew 5", lock_seen, 0);

    // Lane 3 carries a near-miss value in place of the marker
    start(0, 1, 2, 0, 4'b0111);
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk(!lock_seen, "R2", "near-miss value not taken as marker", lock_seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule